// File: doc/BRIEF.md
# Pin Interrupt Detection Unit

This block watches 32 general-purpose input pins and raises one combined interrupt line when an enabled pin reports an event. Each pin is set up on its own. It can use level detection or edge detection. In level mode it can be active-high or active-low. In edge mode it can respond to the rising edge, the falling edge or both. It can also latch events until software clears them (hold) or pass the live condition straight through.

Software reaches the controls over a plain 16-bit register port with a write strobe and a combinational read path. Pins 0 to 15 use the low-half register of each pair. Pins 16 to 31 use the high-half register, which sits two bytes above its low partner. Pending flags are cleared by writing ones. A typical acknowledge first drops the pin's enable bit and then writes a one to its pending bit. Startup does the reverse: it clears the pending bit, then sets the enable bit.

Every pin passes through a two-flop synchroniser. An edge is found by comparing the synchronised value with the value from the cycle before.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset every register reads 0 and `irq_out` is low. A read of any unmapped offset returns 0, and odd byte addresses count as unmapped.
- R2: Each configuration register reads back the value last written to it. The offsets, low half / high half, are:
  - pending 0x08/0x0A
  - enable 0x0C/0x0E
  - mode 0x10/0x12
  - polarity 0x14/0x16
  - hold 0x18/0x1A
  - falling-edge select 0x20/0x22
  - rising-edge select 0x24/0x26

  Bit k of a low-half register belongs to pin k. Bit k of a high-half register belongs to pin 16+k.
- R3: A pin change that is stable before a rising clock edge shows in the pending register after exactly three rising edges, and not after two.
- R4: With the mode bit at 0 (level detection), a polarity bit of 1 makes a high pin active and a polarity bit of 0 makes a low pin active.
- R5: With the mode bit at 1 (edge detection), a rise from 0 to 1 counts only when the rising-select bit is 1, and a fall from 1 to 0 counts only when the falling-select bit is 1. With both select bits set, either edge counts.
- R6: With the hold bit at 1, a pending bit stays set until a write of 1 to that bit. Writing 0 to a pending bit leaves it unchanged.
- R7: With the hold bit at 0, the pending bit follows the detected condition. An edge gives a pending pulse of exactly one cycle.
- R8: If an event arrives in the same cycle that a write of 1 clears the bit, the event wins and the pending bit stays 1.
- R9: `irq_out` is the OR over all 32 pins of (pending AND enable). It is combinational from the registers, so clearing either bit drops it in that cycle.
- R10: Events on pins 16 to 31 appear only in the high-half pending register and leave the low half unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | 32 | Asynchronous general-purpose pin inputs |
| bus_addr | input | 6 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Level detection is tried with both polarities on pins held high and driven low, which shows whether the polarity bit is honoured. It is also tried with a pin sampled two and three edges after it changes, which pins the synchroniser latency.

Edge detection is tried on three pins set to rising-only, falling-only and both, driven through a fall and then a rise. The latched result after each transition tells the three select variants apart. Hold and pass-through are told apart by sampling a rising edge in two consecutive cycles.

A clear written in the exact cycle of a new edge separates the intended "event wins" behaviour from "clear wins". A high-half pin with enable toggled shows that the half mapping and the pending-AND-enable gating are both correct.

// File: rtl/piu_pkg.sv
package piu_pkg;
    localparam int HALF_W = 16;
    localparam int NPINS  = 2 * HALF_W;
    localparam int ADDR_W = 6;

    // Low-half base offsets; the high-half twin sits at base + 2
    localparam logic [ADDR_W-1:0] OFF_PEND = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_EN   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_MODE = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_POL  = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_HOLD = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_FALL = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_RISE = 6'h24;

    typedef struct packed {
        logic [NPINS-1:0] enable;
        logic [NPINS-1:0] edge_mode;
        logic [NPINS-1:0] act_hi;
        logic [NPINS-1:0] hold;
        logic [NPINS-1:0] fall_sel;
        logic [NPINS-1:0] rise_sel;
    } piu_cfg_t;

    typedef struct packed {
        logic [NPINS-1:0] meta;
        logic [NPINS-1:0] cur;
        logic [NPINS-1:0] prev;
    } piu_sync_t;

    typedef struct packed {
        logic [NPINS-1:0] pend;
    } piu_det_t;
endpackage

// File: rtl/piu_sync.sv
module piu_sync
    import piu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_in,
    output logic [NPINS-1:0] cur,
    output logic [NPINS-1:0] prev
);
    piu_sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pins_in;
        s_d.cur  = s_q.meta;
        s_d.prev = s_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur  = s_q.cur;
    assign prev = s_q.prev;

    // R3
    sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 ##1 1'b1 |=> cur == $past(pins_in, 2));
endmodule

// File: rtl/piu_detect.sv
module piu_detect
    import piu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] cur,
    input  logic [NPINS-1:0] prev,
    input  piu_cfg_t         cfg,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] pend
);
    piu_det_t d_d, d_q;
    logic [NPINS-1:0] cond;

    // Per-pin condition: level polarity or selected edge
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic lvl_act, rise_ev, fall_ev;
        always_comb begin
            lvl_act = cfg.act_hi[i] ? cur[i] : ~cur[i];
            rise_ev = cfg.rise_sel[i] &  cur[i] & ~prev[i];
            fall_ev = cfg.fall_sel[i] & ~cur[i] &  prev[i];
            cond[i] = cfg.edge_mode[i] ? (rise_ev | fall_ev) : lvl_act;
        end
    end

    always_comb begin
        d_d      = d_q;
        d_d.pend = (cfg.hold & d_q.pend & ~clr) | cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign pend = d_q.pend;

    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend & $past(pend & cfg.hold & ~clr)) == $past(pend & cfg.hold & ~clr));

    // R8
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend & $past(cond)) == $past(cond));

    // R7
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend ^ $past(cond)) & ~$past(cfg.hold)) == '0);
endmodule

// File: rtl/piu_regs.sv
module piu_regs
    import piu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [HALF_W-1:0] bus_wdata,
    input  logic [NPINS-1:0]  pend,
    output piu_cfg_t          cfg,
    output logic [NPINS-1:0]  clr,
    output logic [HALF_W-1:0] bus_rdata
);
    piu_cfg_t r_d, r_q;
    logic [ADDR_W-1:0] base;
    int unsigned       hs;

    always_comb begin
        base = {bus_addr[ADDR_W-1:2], 2'b00};
        hs   = bus_addr[1] ? HALF_W : 0;
    end

    always_comb begin
        r_d = r_q;
        clr = '0;
        if (bus_wr && !bus_addr[0]) begin
            case (base)
                OFF_PEND: clr[hs +: HALF_W]             = bus_wdata;
                OFF_EN:   r_d.enable[hs +: HALF_W]      = bus_wdata;
                OFF_MODE: r_d.edge_mode[hs +: HALF_W]   = bus_wdata;
                OFF_POL:  r_d.act_hi[hs +: HALF_W]      = bus_wdata;
                OFF_HOLD: r_d.hold[hs +: HALF_W]        = bus_wdata;
                OFF_FALL: r_d.fall_sel[hs +: HALF_W]    = bus_wdata;
                OFF_RISE: r_d.rise_sel[hs +: HALF_W]    = bus_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr[0]) begin
            case (base)
                OFF_PEND: bus_rdata = pend[hs +: HALF_W];
                OFF_EN:   bus_rdata = r_q.enable[hs +: HALF_W];
                OFF_MODE: bus_rdata = r_q.edge_mode[hs +: HALF_W];
                OFF_POL:  bus_rdata = r_q.act_hi[hs +: HALF_W];
                OFF_HOLD: bus_rdata = r_q.hold[hs +: HALF_W];
                OFF_FALL: bus_rdata = r_q.fall_sel[hs +: HALF_W];
                OFF_RISE: bus_rdata = r_q.rise_sel[hs +: HALF_W];
                default:  bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg = r_q;

    // R2
    en_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_EN) |=> cfg.enable[HALF_W-1:0] == $past(bus_wdata));

    // R2
    mode_high_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == (OFF_MODE + 6'd2)) |=> cfg.edge_mode[NPINS-1:HALF_W] == $past(bus_wdata));
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
    import piu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pins_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq_out
);
    logic [NPINS-1:0] cur, prev, clr, pend;
    piu_cfg_t         cfg;

    piu_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_in (pins_in),
        .cur     (cur),
        .prev    (prev)
    );

    piu_detect u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (cur),
        .prev  (prev),
        .cfg   (cfg),
        .clr   (clr),
        .pend  (pend)
    );

    piu_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pend      (pend),
        .cfg       (cfg),
        .clr       (clr),
        .bus_rdata (bus_rdata)
    );

    assign irq_out = |(pend & cfg.enable);

    // R9
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.enable == '0) |-> !irq_out);
endmodule

// File: tb/pin_irq_unit_bench.sv
module pin_irq_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_out;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pin_irq_unit u_pin_irq_unit (
        .clk(clk), .rst_n(rst_n), .pins_in(pins), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        logic [5:0] maps [14] = '{6'h08,6'h0A,6'h0C,6'h0E,6'h10,6'h12,6'h14,6'h16,
                                  6'h18,6'h1A,6'h20,6'h22,6'h24,6'h26};
        for (int i = 0; i < 14; i++) begin
            rd(maps[i], v); check("R1 reset reg", v, 16'h0);
        end
        rd(6'h02, v); check("R1 unmapped 0x02", v, 16'h0);
        rd(6'h1C, v); check("R1 unmapped 0x1C", v, 16'h0);
        wr(6'h0D, 16'hFFFF);
        rd(6'h0D, v); check("R1 odd offset", v, 16'h0);
        rd(6'h0C, v); check("R1 odd write ignored", v, 16'h0);
        check("R1 irq low", {15'h0, irq_out}, 16'h0);
    endtask

    task automatic t_readback;
        logic [15:0] v;
        logic [5:0] bases [6] = '{6'h0C,6'h10,6'h14,6'h18,6'h20,6'h24};
        for (int i = 0; i < 12; i++) begin
            logic [5:0] a;
            a = bases[i/2] + 6'(2 * (i % 2));
            wr(a, 16'h1357 ^ (16'(i) * 16'h0B3D));
        end
        for (int i = 0; i < 12; i++) begin
            logic [5:0] a;
            a = bases[i/2] + 6'(2 * (i % 2));
            rd(a, v); check("R2 readback", v, 16'h1357 ^ (16'(i) * 16'h0B3D));
        end
        for (int i = 0; i < 12; i++) wr(bases[i/2] + 6'(2 * (i % 2)), 16'h0);
        tick(4);
        rd(6'h08, v); check("R2 pend low clean", v, 16'h0);
    endtask

    task automatic t_level;
        logic [15:0] v;
        wr(6'h14, 16'h0001);
        tick(2);
        rd(6'h08, v); check("R4 active-high pin high", v & 16'h3, 16'h1);
        pins[1:0] = 2'b00;
        tick(2);
        rd(6'h08, v); check("R3 not yet after two edges", v & 16'h2, 16'h0);
        tick(1);
        rd(6'h08, v); check("R3 visible after three edges", v & 16'h2, 16'h2);
        check("R4 active-high pin low", v & 16'h1, 16'h0);
        pins[1:0] = 2'b11;
        wr(6'h14, 16'h0000);
        tick(4);
    endtask

    task automatic t_edge_hold;
        logic [15:0] v;
        wr(6'h10, 16'h001C); wr(6'h18, 16'h001C);
        wr(6'h24, 16'h0014); wr(6'h20, 16'h0018);
        wr(6'h08, 16'hFFFF);
        tick(2);
        pins[4:2] = 3'b000;
        tick(3);
        rd(6'h08, v); check("R5 falling edges", v & 16'h1C, 16'h18);
        pins[4:2] = 3'b111;
        tick(3);
        rd(6'h08, v); check("R5 rising edge added", v & 16'h1C, 16'h1C);
        tick(3);
        rd(6'h08, v); check("R6 held", v & 16'h1C, 16'h1C);
        wr(6'h08, 16'h0000);
        rd(6'h08, v); check("R6 write zero no effect", v & 16'h1C, 16'h1C);
        wr(6'h08, 16'h0004);
        rd(6'h08, v); check("R6 clear one bit", v & 16'h1C, 16'h18);
        wr(6'h08, 16'h0018);
        rd(6'h08, v); check("R6 clear rest", v & 16'h1C, 16'h0);
    endtask

    task automatic t_pass;
        logic [15:0] v;
        wr(6'h10, 16'h003C); wr(6'h24, 16'h0034);
        pins[5] = 1'b0;
        tick(4);
        rd(6'h08, v); check("R5 fall ignored when rise-only", v & 16'h20, 16'h0);
        pins[5] = 1'b1;
        tick(3);
        rd(6'h08, v); check("R7 pulse present", v & 16'h20, 16'h20);
        tick(1);
        rd(6'h08, v); check("R7 pulse gone", v & 16'h20, 16'h0);
    endtask

    task automatic t_collide;
        logic [15:0] v;
        wr(6'h10, 16'h007C); wr(6'h18, 16'h005C); wr(6'h24, 16'h0074);
        pins[6] = 1'b0; tick(4);
        pins[6] = 1'b1; tick(4);
        rd(6'h08, v); check("R8 preset", v & 16'h40, 16'h40);
        pins[6] = 1'b0; tick(4);
        pins[6] = 1'b1;
        tick(2);
        wr(6'h08, 16'h0040);
        rd(6'h08, v); check("R8 event beats clear", v & 16'h40, 16'h40);
        wr(6'h08, 16'h0040);
        rd(6'h08, v); check("R8 later clear works", v & 16'h40, 16'h0);
    endtask

    task automatic t_irq;
        logic [15:0] v;
        wr(6'h10, 16'h00FC); wr(6'h18, 16'h00DC); wr(6'h24, 16'h00F4);
        wr(6'h0C, 16'h0080);
        pins[7] = 1'b0; tick(4);
        check("R9 idle irq", {15'h0, irq_out}, 16'h0);
        pins[7] = 1'b1; tick(3);
        check("R9 irq on enabled pend", {15'h0, irq_out}, 16'h1);
        wr(6'h0C, 16'h0000);
        check("R9 irq off when disabled", {15'h0, irq_out}, 16'h0);
        wr(6'h0C, 16'h0080);
        check("R9 irq back", {15'h0, irq_out}, 16'h1);
        wr(6'h08, 16'h0080);
        check("R9 irq after clear", {15'h0, irq_out}, 16'h0);
        wr(6'h12, 16'h0010); wr(6'h1A, 16'h0010); wr(6'h26, 16'h0010);
        wr(6'h0E, 16'h0010);
        pins[20] = 1'b0; tick(4);
        pins[20] = 1'b1; tick(3);
        rd(6'h0A, v); check("R10 high half pend", v, 16'h0010);
        rd(6'h08, v); check("R10 low half untouched", v, 16'h0);
        check("R9 irq from high half", {15'h0, irq_out}, 16'h1);
        wr(6'h0A, 16'h0010);
        check("R9 irq after high clear", {15'h0, irq_out}, 16'h0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_readback();
        t_level();
        t_edge_hold();
        t_pass();
        t_collide();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule